// File: doc/BRIEF.md
# Half-Duplex Carrier Backpressure Engine

This block throttles the far end of a half-duplex Ethernet link without dropping frames. When the local side runs short of resources, it keeps the shared medium busy by sending an idle preamble pattern. Every other station then senses carrier and defers. Backpressure starts and stops on the same resource-shortage request that drives pause-frame flow control on full-duplex ports.

A continuous carrier would trip jabber and excessive-deferral protection in the other stations. To prevent that, the engine limits each carrier burst to a bounded time and then leaves the line silent for a short gap before it raises carrier again. Frames that are waiting locally take priority. The engine releases the line, waits at least one interpacket gap, and then grants the normal transmit MAC the medium until the queue is empty. A collision seen during a silent gap does not start a backoff; carrier is raised again on the next cycle.

One clock cycle carries one byte on the transmit path, so it is worth eight bit times. The burst and gap lengths are parameters given in bit times.

Top module: `hdx_carrier_hold`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the engine is idle: `tx_en` is 0, `txd` is 8'h00 and `mac_grant` is 1.
- R2: In idle, with `bp_req` at 1 and `frame_pending` at 0, `tx_en` goes to 1 one cycle later. While `tx_en` is 1, `txd` is always 8'h55 and never any other value, including the start-of-frame byte 8'hD5. In idle with `frame_pending` at 1, the engine stays idle with `mac_grant` at 1.
- R3: A carrier burst lasts exactly ON_BITS/8 cycles (512 by default). After that, `tx_en` drops.
- R4: A silent gap lasts ceil(GAP_BITS/8) cycles (12 by default) unless a collision cuts it short. If `bp_req` is still 1 and no frame is pending at the end of the gap, `tx_en` returns on the next cycle.
- R5: While carrier is on, `bp_req` at 0 turns `tx_en` off one cycle later. `mac_grant` then stays 0 for a full silent gap and goes to 1 afterwards.
- R6: While carrier is on, `frame_pending` at 1 turns `tx_en` off one cycle later. After the silent gap, `mac_grant` is 1 and stays 1 while `frame_pending` stays 1.
- R7: While granting for pending frames, when `frame_pending` falls, the engine returns to carrier one cycle later if `bp_req` is 1. If `bp_req` is 0, it returns to idle with `mac_grant` at 1.
- R8: During a silent gap, `collision` at 1 together with `bp_req` at 1 sets `tx_en` to 1 one cycle later, with no backoff.
- R9: `collision` has no effect while the MAC holds the grant, and none during a silent gap when `bp_req` is 0.
- R10: `mac_grant` and `tx_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bp_req | input | 1 | Resource shortage: backpressure wanted |
| frame_pending | input | 1 | Local transmit queue is not empty |
| collision | input | 1 | Collision detected on the medium |
| tx_en | output | 1 | Transmit data valid (carrier driven) |
| txd | output | DW | Transmit data byte |
| mac_grant | output | 1 | Normal transmit MAC may use the medium |

## Verification
All outputs decode the registered state, so every response to an input change is due one clock edge after the change. The exception is the end of a timed state, which is due after exactly the counted number of cycles. The bench changes inputs between edges and samples one time unit after each rising edge. It checks the first sample after an input change for the one-cycle responses. For the burst and gap lengths it counts the consecutive samples of `tx_en` or `mac_grant` and compares the count with 512 or 12.

// File: rtl/hdbp_pkg.sv
package hdbp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_JAM   = 2'd1,
    ST_GAP   = 2'd2,
    ST_YIELD = 2'd3
  } hdbp_state_e;

  // Longest carrier burst in byte cycles: rounded down to stay under the limit.
  function automatic int unsigned burst_cycles(input int unsigned bits);
    int unsigned c;
    c = bits / 8;
    return (c == 0) ? 1 : c;
  endfunction

  // Silent gap in byte cycles: rounded up so that at least the gap is kept.
  function automatic int unsigned gap_cycles(input int unsigned bits);
    int unsigned c;
    c = (bits + 7) / 8;
    return (c == 0) ? 1 : c;
  endfunction

  // Alternating idle pattern, lowest bit set (8'h55 for a byte).
  function automatic logic [63:0] idle_pattern(input int unsigned width);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < width) p[i] = ((i % 2) == 0);
    end
    return p;
  endfunction

endpackage

// File: rtl/hdbp_span_counter.sv
module hdbp_span_counter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] term,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != term) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = (cnt_q == term);
endmodule

// File: rtl/hdbp_fsm.sv
module hdbp_fsm
  import hdbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bp_req,
  input  logic        frame_pending,
  input  logic        collision,
  input  logic        span_last,
  output hdbp_state_e state_q,
  output logic        enter_state,
  output logic        burst_expired,
  output logic        gap_done,
  output logic        coll_reassert
);
  hdbp_state_e state_d;

  assign burst_expired = (state_q == ST_JAM) && span_last;
  assign gap_done      = (state_q == ST_GAP) && span_last;
  assign coll_reassert = (state_q == ST_GAP) && collision && bp_req;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (bp_req && !frame_pending) state_d = ST_JAM;
      ST_JAM:   if (!bp_req || frame_pending || span_last) state_d = ST_GAP;
      ST_GAP: begin
        if (coll_reassert)      state_d = ST_JAM;
        else if (span_last) begin
          if (frame_pending)    state_d = ST_YIELD;
          else if (bp_req)      state_d = ST_JAM;
          else                  state_d = ST_IDLE;
        end
      end
      ST_YIELD: if (!frame_pending) state_d = bp_req ? ST_JAM : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign enter_state = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/hdbp_txpath.sv
module hdbp_txpath
  import hdbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  hdbp_state_e   state_q,
  output logic          tx_en,
  output logic [DW-1:0] txd,
  output logic          mac_grant
);
  localparam logic [63:0] PAT_FULL = idle_pattern(DW);
  localparam logic [DW-1:0] PAT = PAT_FULL[DW-1:0];

  assign tx_en     = (state_q == ST_JAM);
  assign mac_grant = (state_q == ST_IDLE) || (state_q == ST_YIELD);
  assign txd       = tx_en ? PAT : '0;
endmodule

// File: rtl/hdx_carrier_hold.sv
module hdx_carrier_hold
  import hdbp_pkg::*;
#(
  parameter int ON_BITS  = 4096,
  parameter int GAP_BITS = 96,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bp_req,
  input  logic          frame_pending,
  input  logic          collision,
  output logic          tx_en,
  output logic [DW-1:0] txd,
  output logic          mac_grant
);
  localparam int ON_CYC  = burst_cycles(ON_BITS);
  localparam int GAP_CYC = gap_cycles(GAP_BITS);
  localparam int MAXC    = (ON_CYC > GAP_CYC) ? ON_CYC : GAP_CYC;
  localparam int CW      = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ON_TERM  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] GAP_TERM = CW'(GAP_CYC - 1);

  hdbp_state_e   state_q;
  logic          enter_state;
  logic          span_last;
  logic          burst_expired;
  logic          gap_done;
  logic          coll_reassert;
  logic [CW-1:0] span_term;

  assign span_term = (state_q == ST_JAM) ? ON_TERM : GAP_TERM;

  hdbp_fsm i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .bp_req        (bp_req),
    .frame_pending (frame_pending),
    .collision     (collision),
    .span_last     (span_last),
    .state_q       (state_q),
    .enter_state   (enter_state),
    .burst_expired (burst_expired),
    .gap_done      (gap_done),
    .coll_reassert (coll_reassert)
  );

  hdbp_span_counter #(.CW(CW)) i_span (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (enter_state),
    .term    (span_term),
    .last    (span_last)
  );

  hdbp_txpath #(.DW(DW)) i_tx (
    .state_q   (state_q),
    .tx_en     (tx_en),
    .txd       (txd),
    .mac_grant (mac_grant)
  );
endmodule

// File: rtl/hdx_carrier_hold_chk.sv
module hdx_carrier_hold_chk #(
  parameter int ON_CYC  = 512,
  parameter int GAP_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic bp_req,
  input logic collision,
  input logic tx_en,
  input logic mac_grant,
  input logic in_gap
);
  localparam int RW = $clog2(ON_CYC + 1);
  localparam int QW = $clog2(GAP_CYC + 1);

  logic [RW-1:0] run_q;
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= '0;
      quiet_q <= QW'(GAP_CYC);
    end else begin
      run_q   <= tx_en ? ((run_q == RW'(ON_CYC)) ? run_q : run_q + 1'b1) : '0;
      quiet_q <= tx_en ? '0 : ((quiet_q == QW'(GAP_CYC)) ? quiet_q : quiet_q + 1'b1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!tx_en && mac_grant));

  assert_carrier_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (run_q < RW'(ON_CYC)));

  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !bp_req) |=> !tx_en);

  assert_gap_before_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_grant) |-> (quiet_q >= QW'(GAP_CYC)));

  assert_coll_reassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_gap && collision && bp_req) |=> tx_en);

  assert_grant_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_en && mac_grant));
endmodule

bind hdx_carrier_hold hdx_carrier_hold_chk #(
  .ON_CYC  (ON_CYC),
  .GAP_CYC (GAP_CYC)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bp_req    (bp_req),
  .collision (collision),
  .tx_en     (tx_en),
  .mac_grant (mac_grant),
  .in_gap    (state_q == hdbp_pkg::ST_GAP)
);

// File: tb/test_hdx_carrier_hold.sv
`timescale 1ns/1ps
module test_hdx_carrier_hold;
  localparam int ON_EXP  = 512;
  localparam int GAP_EXP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bp_req = 1'b0;
  logic frame_pending = 1'b0;
  logic collision = 1'b0;
  logic tx_en;
  logic [7:0] txd;
  logic mac_grant;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hdx_carrier_hold i_hdx_carrier_hold (
    .clk(clk), .rst_n(rst_n), .bp_req(bp_req), .frame_pending(frame_pending),
    .collision(collision), .tx_en(tx_en), .txd(txd), .mac_grant(mac_grant)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Count consecutive samples for which sig equals val, including the current one.
  task automatic count_tx(input logic val, output int n, output int bad_txd);
    n = 0; bad_txd = 0;
    while (tx_en === val && n < 4000) begin
      if (val && txd !== 8'h55) bad_txd++;
      n++;
      step();
    end
  endtask

  task automatic count_nogrant(output int n);
    n = 0;
    while (mac_grant === 1'b0 && n < 4000) begin
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step();
    check("R1", "tx_en in reset", tx_en, 0);
    check("R1", "txd in reset", txd, 0);
    check("R1", "grant in reset", mac_grant, 1);
    rst_n = 1'b1;
    step();
    check("R1", "tx_en after reset", tx_en, 0);
    check("R10", "grant after reset", mac_grant, 1);
  endtask

  task automatic t_burst_and_gap();
    int n, bad;
    frame_pending = 1'b1; bp_req = 1'b1;
    step();
    check("R2", "idle holds with pending frame", tx_en, 0);
    check("R2", "grant with pending frame", mac_grant, 1);
    frame_pending = 1'b0;
    step();
    check("R2", "carrier one cycle after request", tx_en, 1);
    check("R2", "preamble byte", txd, 8'h55);
    check("R10", "no grant during carrier", mac_grant, 0);
    count_tx(1'b1, n, bad);
    check("R3", "burst length", n, ON_EXP);
    check("R2", "non-preamble bytes in burst", bad, 0);
    count_tx(1'b0, n, bad);
    check("R4", "silent gap length", n, GAP_EXP);
    check("R4", "carrier back after gap", tx_en, 1);
  endtask

  task automatic t_release();
    int n;
    bp_req = 1'b0;
    step();
    check("R5", "carrier off after release", tx_en, 0);
    count_nogrant(n);
    check("R5", "no-grant cycles after release", n, GAP_EXP);
    check("R5", "grant after gap", mac_grant, 1);
    check("R5", "carrier stays off in idle", tx_en, 0);
  endtask

  task automatic t_yield();
    int n;
    bp_req = 1'b1;
    step();
    check("R2", "carrier on again", tx_en, 1);
    frame_pending = 1'b1;
    step();
    check("R6", "carrier off for pending frame", tx_en, 0);
    count_nogrant(n);
    check("R6", "gap before grant", n, GAP_EXP);
    repeat (5) step();
    check("R6", "grant held while pending", mac_grant, 1);
    collision = 1'b1;
    repeat (3) step();
    check("R9", "collision ignored while granted (tx_en)", tx_en, 0);
    check("R9", "collision ignored while granted (grant)", mac_grant, 1);
    collision = 1'b0;
    frame_pending = 1'b0;
    step();
    check("R7", "carrier resumes when queue empties", tx_en, 1);
    // second branch: shortage gone before the queue empties
    frame_pending = 1'b1;
    step();
    count_nogrant(n);
    bp_req = 1'b0;
    step();
    frame_pending = 1'b0;
    step();
    check("R7", "idle after queue empties without shortage", tx_en, 0);
    check("R7", "grant kept in idle", mac_grant, 1);
  endtask

  task automatic t_collision();
    bp_req = 1'b1;
    step();
    bp_req = 1'b0;
    step();
    check("R5", "in gap", tx_en, 0);
    collision = 1'b1;
    step();
    check("R9", "collision ignored in gap without shortage", tx_en, 0);
    check("R9", "no grant mid gap", mac_grant, 0);
    bp_req = 1'b1;
    step();
    check("R8", "carrier immediately after collision", tx_en, 1);
    collision = 1'b0;
    bp_req = 1'b0;
    repeat (GAP_EXP + 2) step();
    check("R5", "idle after collision test", mac_grant, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_burst_and_gap();
    t_release();
    t_yield();
    t_collision();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule